// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital control core of a successive-approximation converter. It runs on the system clock and derives an ADC clock from an internal prescaler that counts only while the converter is enabled. Software controls it through level inputs and write pulses: an enable, a start write, a free-running mode, a channel select with a differential flag, and a reference select. The block then produces the timing strobes for the analog side. It issues one step strobe per ADC clock of a conversion, a sample-and-hold strobe half an ADC clock into the sampling cycle, and a result-latch strobe at completion. At completion it also captures the 10-bit word presented by the external comparator/DAC data path and raises a completion flag.

A conversion is normally 13 ADC clocks long. It stretches to 25 ADC clocks for the first conversion after enable, after a change of reference, or when a different differential channel is chosen. The sample point moves with the length. Differential conversions may begin only on alternate ADC clock rising edges, counted from enable. The channel and reference are captured when a conversion begins and are presented on the mux outputs for its whole length.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `en` is low the prescaler is held, no step strobe occurs and a `start_wr` pulse is ignored (`start_bit` stays 0).
- R2: After a `start_wr` pulse on a single-ended channel, the first step strobe appears within one ADC clock (1 to DIV system clocks, DIV = 4 by default), at the next ADC clock rising edge.
- R3: A conversion with `diff_sel` = 1 begins only on the 1st, 3rd, 5th, ... ADC clock rising edge after `en` was set.
- R4: A normal conversion has 13 step strobes, and its result-latch strobe comes 13 ADC clocks after its first step strobe.
- R5: A conversion is extended (25 step strobes, result latch 25 ADC clocks after the first step) when it is the first after `en` rises, when `ref_sel` differs from the previous conversion's, or when `diff_sel` = 1 and the previous conversion was not differential on the same `chan_sel`.
- R6: A differential conversion that repeats the previous conversion's differential channel with the same reference is normal length.
- R7: `sh_strobe` fires 1.5 ADC clocks after the first step strobe of a normal conversion and 13.5 ADC clocks after that of an extended one.
- R8: At the result latch, `result` takes the value of `sar_data` and `done_flag` is set. In single mode (`free_run` = 0) `start_bit` clears in the same cycle.
- R9: In free-running mode with `start_bit` high, the next conversion's first step strobe coincides with the previous result latch.
- R10: `mux_chan`, `mux_diff` and `mux_ref` hold the selections captured at the start of a conversion until its result latch, even if the inputs change meanwhile.
- R11: `done_flag` stays set until a `flag_clr` pulse clears it.
- R12: Dropping `en` during a conversion aborts it: no result latch follows, and `start_bit` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| start_wr | input | 1 | One-cycle pulse that sets the start bit |
| free_run | input | 1 | 1 = free-running mode, 0 = single mode |
| chan_sel | input | 3 | Channel select |
| diff_sel | input | 1 | Selected channel is differential |
| ref_sel | input | 2 | Reference select |
| flag_clr | input | 1 | One-cycle pulse that clears the completion flag |
| sar_data | input | 10 | Result word from the comparator/DAC data path |
| start_bit | output | 1 | Start bit as seen by software |
| sh_strobe | output | 1 | Sample-and-hold strobe, one system clock |
| step_strobe | output | 1 | One pulse per ADC clock of a conversion |
| res_latch | output | 1 | Result-latch strobe at completion |
| done_flag | output | 1 | Completion flag |
| result | output | 10 | Latched conversion result |
| mux_chan | output | 3 | Channel captured for the current conversion |
| mux_diff | output | 1 | Differential flag captured for the current conversion |
| mux_ref | output | 2 | Reference captured for the current conversion |

## Verification
The assertions check several properties on every cycle. The prescaler must stay silent while disabled, and no step or latch may follow a drop of enable. The cycle counter must stay within the current conversion length. Single-mode completion must clear the start bit and set the flag, and a flag clear must take effect. Only the bench's scenarios can show the timing relations measured across a whole conversion. These are the 13 or 25 step count, the sample offset, the start latency, the alternate-edge rule for differential starts, and the choice of extended length after enable, reference changes and differential channel changes. Back-to-back free-running starts and the holding of captured selections also need those scenarios.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int CH_W  = 3;
  parameter int REF_W = 2;
  parameter int RES_W = 10;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic             diff;
    logic [REF_W-1:0] refsel;
  } sel_t;
endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic rise_tick,
  output logic fall_tick,
  output logic alt_ok
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          par_q, par_d;

  assign rise_tick = en && (cnt_q == LAST);
  assign fall_tick = en && (cnt_q == HALF);
  assign alt_ok    = !par_q;

  always_comb begin
    cnt_d = '0;
    par_d = 1'b0;
    if (en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      par_d = rise_tick ? !par_q : par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      par_q <= par_d;
    end
  end

  p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rise_tick && !fall_tick));
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !rise_tick);
endmodule

// File: rtl/adc_seq_extdet.sv
module adc_seq_extdet
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  sel_t sel_in,
  output logic ext_need
);
  logic pend_q, pend_d;
  sel_t last_q, last_d;

  always_comb begin
    pend_d = pend_q;
    last_d = last_q;
    if (!en) pend_d = 1'b1;
    else if (load) begin
      pend_d = 1'b0;
      last_d = sel_in;
    end
  end

  assign ext_need = pend_q
                 || (sel_in.refsel != last_q.refsel)
                 || (sel_in.diff && !(last_q.diff && (sel_in.chan == last_q.chan)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      last_q <= last_d;
    end
  end

  p_first_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(!en)) |-> ext_need);
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25,
  parameter int SH_NORM  = 2,
  parameter int SH_EXT   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_wr,
  input  logic             free_run,
  input  sel_t             sel_in,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] sar_data,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             alt_ok,
  input  logic             ext_need,
  output logic             start_now,
  output logic             start_bit,
  output logic             sh_strobe,
  output logic             step_strobe,
  output logic             res_latch,
  output logic             done_flag,
  output logic [RES_W-1:0] result,
  output sel_t             sel_conv
);
  localparam int CYW = $clog2(EXT_CYC + 1);
  localparam logic [CYW-1:0] LEN_N = CYW'(NORM_CYC);
  localparam logic [CYW-1:0] LEN_E = CYW'(EXT_CYC);
  localparam logic [CYW-1:0] SHC_N = CYW'(SH_NORM);
  localparam logic [CYW-1:0] SHC_E = CYW'(SH_EXT);

  logic             busy_q, busy_d, ext_q, ext_d, start_q, start_d;
  logic             done_q, done_d, step_q, step_d, sh_q, sh_d, lat_q, lat_d;
  logic [CYW-1:0]   cyc_q, cyc_d;
  logic [RES_W-1:0] res_q, res_d;
  sel_t             sel_q, sel_d;
  logic             last_cyc, fin, start_eff, diff_ok;

  assign last_cyc  = busy_q && (cyc_q == (ext_q ? LEN_E : LEN_N));
  assign fin       = en && rise_tick && last_cyc;
  assign start_eff = start_q && !(fin && !free_run);
  assign diff_ok   = !sel_in.diff || alt_ok;
  assign start_now = en && rise_tick && start_eff && diff_ok && (!busy_q || last_cyc);

  always_comb begin
    busy_d  = busy_q;
    ext_d   = ext_q;
    cyc_d   = cyc_q;
    sel_d   = sel_q;
    start_d = start_q;
    if (!en) begin
      busy_d  = 1'b0;
      cyc_d   = '0;
      start_d = 1'b0;
    end else begin
      if (fin && !free_run) start_d = 1'b0;
      if (start_wr)         start_d = 1'b1;
      if (start_now) begin
        busy_d = 1'b1;
        cyc_d  = CYW'(1);
        ext_d  = ext_need;
        sel_d  = sel_in;
      end else if (fin) begin
        busy_d = 1'b0;
        cyc_d  = '0;
      end else if (busy_q && rise_tick) begin
        cyc_d = cyc_q + CYW'(1);
      end
    end
    step_d = start_now || (en && rise_tick && busy_q && !last_cyc);
    sh_d   = en && fall_tick && busy_q && (cyc_q == (ext_q ? SHC_E : SHC_N));
    lat_d  = fin;
    res_d  = fin ? sar_data : res_q;
    done_d = fin || (done_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ext_q   <= 1'b0;
      cyc_q   <= '0;
      sel_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= 1'b0;
      sh_q    <= 1'b0;
      lat_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      ext_q   <= ext_d;
      cyc_q   <= cyc_d;
      sel_q   <= sel_d;
      start_q <= start_d;
      done_q  <= done_d;
      step_q  <= step_d;
      sh_q    <= sh_d;
      lat_q   <= lat_d;
      res_q   <= res_d;
    end
  end

  assign start_bit   = start_q;
  assign sh_strobe   = sh_q;
  assign step_strobe = step_q;
  assign res_latch   = lat_q;
  assign done_flag   = done_q;
  assign result      = res_q;
  assign sel_conv    = sel_q;

  p_step_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> $past(en));
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cyc_q <= (ext_q ? LEN_E : LEN_N)));
  p_sh_in_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q |-> busy_q);
  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !free_run && !start_wr) |=> (!start_q && done_q && lat_q));
  p_free_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && free_run && start_q && diff_ok) |=> (step_q && busy_q && lat_q));
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fin) |=> !done_q);
  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy_q && !step_q && !lat_q && !start_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25,
  parameter int SH_NORM  = 2,
  parameter int SH_EXT   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_wr,
  input  logic             free_run,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             diff_sel,
  input  logic [REF_W-1:0] ref_sel,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] sar_data,
  output logic             start_bit,
  output logic             sh_strobe,
  output logic             step_strobe,
  output logic             res_latch,
  output logic             done_flag,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  mux_chan,
  output logic             mux_diff,
  output logic [REF_W-1:0] mux_ref
);
  logic [1:0] rst_sync;
  logic       rst_s;
  logic       rise_tick, fall_tick, alt_ok, ext_need, start_now;
  sel_t       sel_in, sel_conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign sel_in = '{chan: chan_sel, diff: diff_sel, refsel: ref_sel};

  adc_seq_presc #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_s), .en(en),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .alt_ok(alt_ok)
  );

  adc_seq_extdet u_ext (
    .clk(clk), .rst_n(rst_s), .en(en), .load(start_now),
    .sel_in(sel_in), .ext_need(ext_need)
  );

  adc_seq_core #(
    .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC), .SH_NORM(SH_NORM), .SH_EXT(SH_EXT)
  ) u_core (
    .clk(clk), .rst_n(rst_s), .en(en), .start_wr(start_wr),
    .free_run(free_run), .sel_in(sel_in), .flag_clr(flag_clr),
    .sar_data(sar_data), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .alt_ok(alt_ok), .ext_need(ext_need), .start_now(start_now),
    .start_bit(start_bit), .sh_strobe(sh_strobe), .step_strobe(step_strobe),
    .res_latch(res_latch), .done_flag(done_flag), .result(result),
    .sel_conv(sel_conv)
  );

  assign mux_chan = sel_conv.chan;
  assign mux_diff = sel_conv.diff;
  assign mux_ref  = sel_conv.refsel;
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NLEN = 13;
  localparam int ELEN = 25;

  logic clk = 1'b0;
  logic rst_n, en, start_wr, free_run, diff_sel, flag_clr;
  logic [2:0] chan_sel;
  logic [1:0] ref_sel;
  logic [9:0] sar_data;
  logic start_bit, sh_strobe, step_strobe, res_latch, done_flag, mux_diff;
  logic [9:0] result;
  logic [2:0] mux_chan;
  logic [1:0] mux_ref;

  int checks = 0, fails = 0;
  int n = 0, n_en = 0, t_first = 0, steps = 0, lat_cnt = 0, first_cnt = 0;
  bit active = 0, pend = 1, e_ext = 0, l_diff = 0;
  logic [2:0] l_chan = 0, c_chan = 0;
  logic [1:0] l_ref = 0, c_ref = 0;
  bit c_diff = 0;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .start_wr(start_wr), .free_run(free_run),
    .chan_sel(chan_sel), .diff_sel(diff_sel), .ref_sel(ref_sel), .flag_clr(flag_clr),
    .sar_data(sar_data), .start_bit(start_bit), .sh_strobe(sh_strobe),
    .step_strobe(step_strobe), .res_latch(res_latch), .done_flag(done_flag),
    .result(result), .mux_chan(mux_chan), .mux_diff(mux_diff), .mux_ref(mux_ref)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic bit want_ext(input bit p, input logic [1:0] r, input bit d,
                                  input logic [2:0] c);
    return p || (r != l_ref) || (d && !(l_diff && c == l_chan));
  endfunction

  function automatic int len_of(input bit x);
    return x ? ELEN : NLEN;
  endfunction

  function automatic int sh_off(input bit x);
    return x ? (13 * DIV + DIV / 2) : (DIV + DIV / 2);
  endfunction

  always @(negedge clk) begin
    n++;
    if (!en) begin
      active = 0;
      pend = 1;
    end
    if (res_latch) begin
      chk(active, "R8 latch inside conversion", active, 1);
      chk(steps == len_of(e_ext), e_ext ? "R5 step count" : (c_diff ? "R6 step count" : "R4 step count"),
          steps, len_of(e_ext));
      chk(n - t_first == len_of(e_ext) * DIV, e_ext ? "R5 latch time" : "R4 latch time",
          n - t_first, len_of(e_ext) * DIV);
      chk(result == sar_data, "R8 result", result, sar_data);
      chk(done_flag, "R8 done flag", done_flag, 1);
      chk(mux_chan == c_chan && mux_ref == c_ref && mux_diff == c_diff, "R10 held selection",
          {mux_chan, mux_diff, mux_ref}, {c_chan, c_diff, c_ref});
      if (!free_run) chk(!start_bit, "R8 start bit cleared", start_bit, 0);
      else if (!diff_sel) chk(step_strobe, "R9 immediate restart", step_strobe, 1);
      lat_cnt++;
      active = 0;
    end
    if (step_strobe) begin
      if (!active) begin
        c_chan = chan_sel; c_ref = ref_sel; c_diff = diff_sel;
        e_ext = want_ext(pend, ref_sel, diff_sel, chan_sel);
        pend = 0; l_chan = chan_sel; l_ref = ref_sel; l_diff = diff_sel;
        if (diff_sel)
          chk(((n - n_en - DIV) % (2 * DIV)) == 0, "R3 alternate-edge start",
              (n - n_en - DIV) % (2 * DIV), 0);
        active = 1;
        steps = 1;
        t_first = n;
        first_cnt++;
      end else steps++;
    end
    if (sh_strobe)
      chk(active && (n - t_first == sh_off(e_ext)), "R7 sample point", n - t_first, sh_off(e_ext));
  end

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic enable_on();
    @(negedge clk); #1;
    en = 1'b1;
    n_en = n;
  endtask

  task automatic run_one(input bit lat_chk);
    int old, wr_n;
    old = lat_cnt;
    @(negedge clk); #1;
    start_wr = 1'b1; wr_n = n;
    @(negedge clk); #1;
    start_wr = 1'b0;
    while (lat_cnt == old) begin @(negedge clk); #2; end
    if (lat_chk)
      chk(t_first - wr_n >= 2 && t_first - wr_n <= DIV + 1, "R2 start latency",
          t_first - wr_n - 1, DIV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int old;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; en = 0; start_wr = 0; free_run = 0; diff_sel = 0; flag_clr = 0;
    chan_sel = 3'd1; ref_sel = 2'd0; sar_data = 10'h155;
    tick(3);
    chk(!start_bit && !done_flag && !step_strobe && !res_latch && !sh_strobe && result == 0,
        "R8 reset state", {start_bit, done_flag, step_strobe, res_latch}, 0);
    rst_n = 1;
    tick(4);

    // R1: start write while disabled is ignored
    start_wr = 1; tick(1); start_wr = 0;
    old = first_cnt;
    tick(60);
    chk(!start_bit, "R1 start ignored when off", start_bit, 0);
    chk(first_cnt == old, "R1 no steps when off", first_cnt - old, 0);

    // first conversion after enable is extended, next is normal
    enable_on();
    tick(5);
    sar_data = 10'h2a7; run_one(1);
    sar_data = 10'h0c3; run_one(1);
    chk(e_ext == 0, "R4 second conversion normal", e_ext, 0);
    // reference change forces extended
    ref_sel = 2'd2; sar_data = 10'h3ff; run_one(1);
    chk(e_ext == 1, "R5 reference change extends", e_ext, 1);

    // R11 flag stays, then clears
    tick(7);
    chk(done_flag, "R11 flag held", done_flag, 1);
    flag_clr = 1; tick(1); flag_clr = 0;
    tick(1);
    chk(!done_flag, "R11 flag cleared", done_flag, 0);

    // differential: new channel extended, repeat normal, other channel extended
    diff_sel = 1; chan_sel = 3'd4; run_one(0);
    chk(e_ext == 1, "R5 differential select extends", e_ext, 1);
    run_one(0);
    chk(e_ext == 0, "R6 same differential channel normal", e_ext, 0);
    tick(3); run_one(0);
    chan_sel = 3'd5; run_one(0);
    chk(e_ext == 1, "R5 other differential channel extends", e_ext, 1);
    diff_sel = 0;

    // R10: change selections mid-conversion
    old = lat_cnt;
    @(negedge clk); #1; start_wr = 1; tick(1); start_wr = 0;
    tick(6 * DIV);
    chan_sel = 3'd6; ref_sel = 2'd3;
    while (lat_cnt == old) begin @(negedge clk); #2; end
    chk(c_ref == 2'd2, "R10 reference captured at start", c_ref, 2);

    // R9: free-running chain of three, then stop
    free_run = 1;
    old = lat_cnt;
    @(negedge clk); #1; start_wr = 1; tick(1); start_wr = 0;
    while (lat_cnt < old + 3) begin @(negedge clk); #2; end
    chk(start_bit, "R9 start bit stays in free run", start_bit, 1);
    free_run = 0;
    old = lat_cnt;
    while (lat_cnt == old) begin @(negedge clk); #2; end
    tick(2 * DIV);
    chk(!start_bit && !active, "R9 chain stops in single mode", start_bit, 0);

    // R12: abort
    old = lat_cnt;
    @(negedge clk); #1; start_wr = 1; tick(1); start_wr = 0;
    tick(10 * DIV);
    en = 0; tick(3);
    chk(!start_bit, "R12 start bit cleared on abort", start_bit, 0);
    tick(40 * DIV);
    chk(lat_cnt == old, "R12 no latch after abort", lat_cnt - old, 0);
    enable_on();
    old = first_cnt;
    tick(40 * DIV);
    chk(first_cnt == old, "R12 no spontaneous restart", first_cnt - old, 0);
    run_one(1);
    chk(e_ext == 1, "R5 first after re-enable extended", e_ext, 1);

    // constrained random single conversions
    for (int i = 0; i < 30; i++) begin
      sar_data = 10'($urandom);
      if ($urandom_range(3) == 0) ref_sel = 2'($urandom);
      if ($urandom_range(1) == 0) chan_sel = 3'($urandom);
      diff_sel = ($urandom_range(2) == 0);
      if ($urandom_range(3) == 0) begin flag_clr = 1; tick(1); flag_clr = 0; end
      tick($urandom_range(9));
      run_one(!diff_sel);
    end

    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule